// File: doc/BRIEF.md
# Input Change Interrupt Controller

The block watches a bank of asynchronous input lines and raises one interrupt when any enabled line changes level. Each line passes through a synchronizer, and its synchronized value is compared with the value it had one clock earlier. Any difference on a line, whether a rise or a fall, marks an event on that line. The event sets a sticky per-line pending bit. The pending bit is set even when the line's interrupt is disabled.

Software controls the block through a small synchronous register bus. Two write-only ports change the enable mask: one sets the bits written as 1, the other clears them. The mask itself can be read back. A read of the pending register returns every pending bit and clears them all in the same access. If an event arrives in the cycle of that read, it survives the read and is reported by the next one. The interrupt output is registered. It is high whenever a pending bit and its enable bit are both set.

Top module: `chg_irq_ctrl`

## Requirements
- R1: After reset the enable mask, the pending bits and irq_o are all 0. No event is flagged while the synchronizer and compare stage fill, even when lines_i is non-zero during and after reset.
- R2: A level change on a line, rising or falling, sets that line's pending bit. The bit is visible at the third rising clock edge after the input changes (two synchronizer flops, then the pending register).
- R3: A bus write (req_i=1, we_i=1) to address 0 sets every mask bit whose wdata_i bit is 1. Bits written as 0 leave their mask bits unchanged.
- R4: A bus write to address 1 clears every mask bit whose wdata_i bit is 1. Bits written as 0 leave their mask bits unchanged.
- R5: A read (req_i=1, we_i=0) of address 2 returns the mask on rdata_o from the clock edge that accepts the read.
- R6: A pending bit is set by an event whether or not that line's mask bit is set.
- R7: irq_o is 1 exactly when some line has both its pending bit and its mask bit set. It is updated at the same edge as those registers.
- R8: A read of address 3 returns all pending bits on rdata_o and clears them all at the same edge. irq_o is therefore low after that edge unless a new enabled event arrives.
- R9: An event detected in the cycle of a pending-register read is not returned by that read, and its bit stays set after the read.
- R10: Lines are independent. Several lines changing together each set only their own bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lines_i | input | 32 | Asynchronous input lines |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | 0 mask set, 1 mask clear, 2 mask read, 3 pending read-and-clear |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered at the accepting edge |
| irq_o | output | 1 | Interrupt, OR of pending and enabled lines |

## Verification
The assertions assume the bus drives defined values on every edge after reset, and that a read and a write are never requested in the same cycle. The stimulus keeps within this by driving the bus and the lines only at falling edges, with one access per request. The assertions also assume lines_i is held stable during reset, so the synchronizer fills with a single value. The bench holds a fixed non-zero pattern on lines_i through reset and changes it only afterwards.

// File: rtl/chg_irq_pkg.sv
package chg_irq_pkg;
  typedef enum logic [1:0] {
    REG_MSET = 2'd0,
    REG_MCLR = 2'd1,
    REG_MASK = 2'd2,
    REG_PEND = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/chg_detect.sv
module chg_detect #(
  parameter int unsigned W        = 32,
  parameter int unsigned FILL_CYC = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] smp_i,
  output logic [W-1:0] chg_o
);
  localparam int unsigned CW = $clog2(FILL_CYC + 1);

  logic [W-1:0]  prev_q;
  logic [CW-1:0] fill_q;
  logic          armed;

  assign armed = (fill_q == CW'(FILL_CYC));

  // prev always follows the sample; compare is gated until pipeline is full
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      fill_q <= '0;
    end else begin
      prev_q <= smp_i;
      if (!armed) fill_q <= fill_q + 1'b1;
    end
  end

  assign chg_o = armed ? (smp_i ^ prev_q) : '0;

  // R2
  ev_polarity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |=> ((chg_o & ~($past(smp_i) ^ smp_i)) == '0));
endmodule

// File: rtl/chg_regs.sv
module chg_regs
  import chg_irq_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] chg_i,
  input  logic         req_i,
  input  logic         we_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic         irq_o
);
  reg_sel_e     sel;
  logic         wr_set, wr_clr, rd_mask, rd_pend;
  logic [W-1:0] mask_q, mask_d, pend_q, pend_d, rdata_q;
  logic         irq_q;

  assign sel     = reg_sel_e'(addr_i);
  assign wr_set  = req_i &  we_i & (sel == REG_MSET);
  assign wr_clr  = req_i &  we_i & (sel == REG_MCLR);
  assign rd_mask = req_i & ~we_i & (sel == REG_MASK);
  assign rd_pend = req_i & ~we_i & (sel == REG_PEND);

  always_comb begin
    mask_d = mask_q;
    if (wr_set) mask_d = mask_q | wdata_i;
    if (wr_clr) mask_d = mask_q & ~wdata_i;
  end

  // new events win over the clearing read
  assign pend_d = (rd_pend ? '0 : pend_q) | chg_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      pend_q  <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      mask_q <= mask_d;
      pend_q <= pend_d;
      irq_q  <= |(pend_d & mask_d);
      if (rd_mask)      rdata_q <= mask_q;
      else if (rd_pend) rdata_q <= pend_q;
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;

  // R3
  mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));
  // R4
  mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> ((mask_q & $past(wdata_i)) == '0));
  // R6
  pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_i != '0) |=> ((pend_q & $past(chg_i)) == $past(chg_i)));
  // R8
  pend_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pend |=> ((pend_q & ~$past(chg_i)) == '0));
  // R7
  irq_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(pend_q & mask_q));
endmodule

// File: rtl/chg_irq_ctrl.sv
module chg_irq_ctrl #(
  parameter int unsigned NUM_LINES   = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] lines_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [1:0]           addr_i,
  input  logic [NUM_LINES-1:0] wdata_i,
  output logic [NUM_LINES-1:0] rdata_o,
  output logic                 irq_o
);
  localparam int unsigned FILL_CYC = SYNC_STAGES + 1;

  logic [NUM_LINES-1:0] smp, chg;

  chg_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .d_i(lines_i), .q_o(smp));

  chg_detect #(.W(NUM_LINES), .FILL_CYC(FILL_CYC)) i_detect (
    .clk_i, .rst_ni, .smp_i(smp), .chg_o(chg));

  chg_regs #(.W(NUM_LINES)) i_regs (
    .clk_i, .rst_ni, .chg_i(chg), .req_i, .we_i, .addr_i, .wdata_i,
    .rdata_o, .irq_o);
endmodule

// File: tb/test_chg_irq_ctrl.sv
module test_chg_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] lines = 32'hA5A5_0F0F;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  chg_irq_ctrl i_chg_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .lines_i(lines), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    tick(1);
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    tick(1);
    req = 1'b0;
    d = rdata;
  endtask

  // toggle lines and wait until pending bits are visible
  task automatic flip(input logic [31:0] m);
    lines = lines ^ m;
    tick(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d, m;
    tick(3);
    rst_ni = 1'b1;
    tick(8);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    bus_rd(2'd3, d); chk("R1 pending", d, 32'd0);
    bus_rd(2'd2, d); chk("R1 mask", d, 32'd0);

    // R2 R6 R8 R10: per-line sweep, both polarities, mask off
    for (int i = 0; i < 32; i++) begin
      flip(32'd1 << i);
      chk("R6 irq stays low unmasked", {31'd0, irq}, 32'd0);
      bus_rd(2'd3, d); chk("R2 rise/fall sets own bit", d, 32'd1 << i);
      bus_rd(2'd3, d); chk("R8 cleared by read", d, 32'd0);
      flip(32'd1 << i);
      bus_rd(2'd3, d); chk("R2 reverse edge", d, 32'd1 << i);
    end

    // R2 latency: after two edges nothing, after third set
    lines = lines ^ 32'h0000_0010;
    tick(1);
    bus_rd(2'd3, d); chk("R2 not yet", d, 32'd0);
    tick(1);
    bus_rd(2'd3, d); chk("R2 third edge", d, 32'h0000_0010);

    // R3 R4 R5 mask control
    bus_wr(2'd0, 32'hF0F0_00FF);
    bus_rd(2'd2, d); chk("R3 set", d, 32'hF0F0_00FF);
    bus_wr(2'd0, 32'h0000_0000);
    bus_rd(2'd2, d); chk("R3 zeros ignored", d, 32'hF0F0_00FF);
    bus_wr(2'd1, 32'h3000_000F);
    bus_rd(2'd2, d); chk("R4 clear", d, 32'hC0F0_00F0);
    bus_wr(2'd1, 32'h0000_0000);
    bus_rd(2'd2, d); chk("R4 zeros ignored", d, 32'hC0F0_00F0);
    bus_wr(2'd1, 32'hFFFF_FFFF);
    bus_rd(2'd2, d); chk("R5 all clear", d, 32'd0);

    // R7 R8 per-line irq sweep
    for (int i = 0; i < 32; i++) begin
      m = 32'd1 << i;
      bus_wr(2'd0, m);
      flip(32'd1 << ((i + 1) % 32));
      chk("R7 other line no irq", {31'd0, irq}, 32'd0);
      flip(m);
      chk("R7 irq on enabled line", {31'd0, irq}, 32'd1);
      bus_rd(2'd3, d);
      chk("R8 pending both", d, m | (32'd1 << ((i + 1) % 32)));
      chk("R8 irq low after read", {31'd0, irq}, 32'd0);
      bus_wr(2'd1, m);
    end

    // R10 multi-line
    flip(32'h8001_2480);
    bus_rd(2'd3, d); chk("R10 multi-line", d, 32'h8001_2480);

    // R7 enabling after the event raises irq
    flip(32'h0000_0200);
    chk("R7 pre-enable", {31'd0, irq}, 32'd0);
    bus_wr(2'd0, 32'h0000_0200);
    chk("R7 post-enable", {31'd0, irq}, 32'd1);
    bus_wr(2'd1, 32'h0000_0200);
    chk("R7 post-disable", {31'd0, irq}, 32'd0);
    bus_rd(2'd3, d);

    // R9 event coinciding with clearing read
    bus_wr(2'd0, 32'h0400_0000);
    lines = lines ^ 32'h0400_0000;
    tick(1);
    tick(0);
    bus_rd(2'd3, d); chk("R9 read misses race event", d, 32'd0);
    chk("R9 irq kept", {31'd0, irq}, 32'd1);
    bus_rd(2'd3, d); chk("R9 event kept", d, 32'h0400_0000);
    chk("R9 irq cleared", {31'd0, irq}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule